// File: doc/BRIEF.md
# Data Window Address Translator

The translator turns a logical data offset into a physical address and a memory-space code. The 16-bit logical space is divided into equal windows, and each window has a 16-bit map register. A window's map register either points it at a segment of unified, instruction or internal data memory, or switches it to an I/O mode. In I/O mode, one of four 4-bit page numbers held in the register picks a 64 KiB page, and the access lands at a fixed 0xC000 base inside that page.

Each lookup also carries a byte count. The translator returns a length clipped so that the transfer stops at the end of the window it starts in. Offsets past the logical space and windows marked reserved produce an error and a zero length. The map registers are loaded through a write port addressed like data memory. One extra alias address reaches the third register. The lookup path is purely combinational from the offset, the count and the current map register contents.

Top module: `dwat_top`

## Requirements
- R1: The window index is logical offset bits 15:14 and the in-window offset is bits 13:0 (window size 0x4000 bytes, four windows).
- R2: With the default strict setting, a 17-bit lookup offset of 0x10000 or more gives error 1, length 0, space code 3 and physical address 0.
- R3: With the wrapping setting, bit 16 of the lookup offset is dropped and the result equals the lookup of the low 16 bits.
- R4: The returned length is the byte count, unless in-window offset plus count exceeds 0x4000; in that case it is 0x4000 minus the in-window offset.
- R5: Map bits 13:12 = 00 (bit 15 clear) select unified space, code 0, physical = map[9:0]*0x4000 + in-window offset.
- R6: Map bits 13:12 = 01 (bit 15 clear) select instruction space, code 1, with the same address rule as R5.
- R7: Map bits 13:12 = 10 (bit 15 clear) select internal data space, code 2, physical = map[9:0]*0x10000 + window index*0x4000 + in-window offset.
- R8: Map bits 13:12 = 11 (bit 15 clear) are reserved: error 1, length 0, space code 3, physical 0.
- R9: Map bit 15 set selects I/O mode, overriding bits 13:12. The sub-page s = in-window offset bits 13:12, the page is map bits [4*(3-s)+3 : 4*(3-s)], physical = page*0x10000 + 0xC000 + in-window offset, and the space code is 2.
- R10: A write to address 0xFF08 + 2*n loads map register n (n = 0..3), a write to 0xFF04 loads map register 2, and a write to any other address changes no register.
- R11: After reset, map registers 0, 1 and 2 hold 0x2000 and map register 3 holds 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the map registers |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Map register write strobe |
| wr_addr | input | 16 | Data address of the write |
| wr_data | input | 16 | Value written to the selected map register |
| lk_offset | input | 17 | Logical offset; bit 16 marks an offset beyond the 16-bit space |
| lk_count | input | 16 | Requested byte count |
| lk_paddr | output | 26 | Translated physical address |
| lk_space | output | 2 | Space code: 0 unified, 1 instruction, 2 data, 3 none/error |
| lk_len | output | 16 | Clipped byte count |
| lk_err | output | 1 | Lookup unsupported (out of range or reserved space) |

## Verification
The clocked assertions on the lookup outputs assume that the offset and count hold steady around each rising edge, so a combinational result sampled at the edge belongs to a single request. The stimulus changes the lookup inputs and the write port only on falling edges. Writes are single-cycle strobes with no lookup checked in the same cycle. The write-port assertions take it that reset is not raised in the cycle after a write, and the bench asserts reset only at the start.

// File: rtl/dwat_pkg.sv
package dwat_pkg;
  typedef enum logic [1:0] {
    SPC_UNIFIED = 2'd0,
    SPC_INSN    = 2'd1,
    SPC_DATA    = 2'd2,
    SPC_NONE    = 2'd3
  } dwat_space_e;

  // map register field positions
  localparam int MAP_IO_BIT = 15;
  localparam int MAP_SP_HI  = 13;
  localparam int MAP_SP_LO  = 12;
  localparam int DATA_SEG_SHIFT = 16;
  localparam int IO_PAGE_SHIFT  = 16;
  localparam logic [15:0] IO_BASE = 16'hC000;
endpackage

// File: rtl/dwat_mapregs.sv
module dwat_mapregs #(
  parameter int NUM_WIN = 4,
  parameter int REG_W   = 16,
  parameter int ADDR_W  = 16,
  parameter logic [15:0] MAP_BASE    = 16'hFF08,
  parameter logic [15:0] SHADOW_ADDR = 16'hFF04,
  parameter int          SHADOW_IDX  = 2,
  parameter logic [15:0] RST_MAIN    = 16'h2000,
  parameter logic [15:0] RST_LAST    = 16'h0000
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [REG_W-1:0]                wr_data,
  output logic [NUM_WIN-1:0][REG_W-1:0]   maps
);
  logic [NUM_WIN-1:0] hit;

  generate
    for (genvar n = 0; n < NUM_WIN; n++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(MAP_BASE) + 2 * n);
      localparam logic [REG_W-1:0]  MY_RST  = (n == NUM_WIN - 1) ? REG_W'(RST_LAST)
                                                                : REG_W'(RST_MAIN);
      logic [REG_W-1:0] q;
      if (n == SHADOW_IDX) begin : g_alias
        assign hit[n] = wr_en && ((wr_addr == MY_ADDR) ||
                                  (wr_addr == ADDR_W'(SHADOW_ADDR)));
      end else begin : g_plain
        assign hit[n] = wr_en && (wr_addr == MY_ADDR);
      end
      always_ff @(posedge clk) begin
        if (rst)         q <= MY_RST;
        else if (hit[n]) q <= wr_data;
      end
      assign maps[n] = q;
    end
  endgenerate

  // R10: at most one register takes a write
  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  // R10: the alias address lands in the shadowed register
  a_r10_shadow_alias: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(SHADOW_ADDR)) |=> maps[SHADOW_IDX] == $past(wr_data));

  // R10: undecoded writes leave every register alone
  a_r10_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit == '0) |=> $stable(maps));
endmodule

// File: rtl/dwat_xlate.sv
module dwat_xlate
  import dwat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 16,
  parameter int REG_W   = 16,
  parameter int SEG_W   = 10,
  parameter int PHYS_W  = 26,
  parameter int CNT_W   = 16,
  parameter bit WRAP    = 1'b0
) (
  input  logic [NUM_WIN-1:0][REG_W-1:0] maps,
  input  logic [ADDR_W:0]               lk_offset,
  input  logic [CNT_W-1:0]              lk_count,
  output logic [PHYS_W-1:0]             lk_paddr,
  output logic [1:0]                    lk_space,
  output logic [CNT_W-1:0]              lk_len,
  output logic                          lk_err
);
  localparam int IDX_W     = $clog2(NUM_WIN);
  localparam int WIN_W     = ADDR_W - IDX_W;
  localparam int WIN_BYTES = 1 << WIN_W;

  logic              out_rng;
  logic [ADDR_W-1:0] la;
  logic [IDX_W-1:0]  win_idx;
  logic [WIN_W-1:0]  woff;
  logic [REG_W-1:0]  map_w;

  generate
    if (WRAP) begin : g_wrap
      assign out_rng = 1'b0;
    end else begin : g_strict
      assign out_rng = lk_offset[ADDR_W];
    end
  endgenerate

  assign la      = lk_offset[ADDR_W-1:0];
  assign win_idx = la[ADDR_W-1:WIN_W];
  assign woff    = la[WIN_W-1:0];
  assign map_w   = maps[win_idx];

  function automatic logic [CNT_W-1:0] clip_len(input logic [WIN_W-1:0] o,
                                                input logic [CNT_W-1:0] c);
    logic [CNT_W:0] room;
    room = (CNT_W+1)'(WIN_BYTES) - (CNT_W+1)'(o);
    if ({1'b0, c} > room) return room[CNT_W-1:0];
    return c;
  endfunction

  function automatic logic [3:0] io_page(input logic [REG_W-1:0] m,
                                         input logic [WIN_W-1:0] o);
    logic [1:0] sub;
    logic [REG_W-1:0] sh;
    sub = o[13:12];
    sh  = m >> (4 * (3 - int'(sub)));
    return sh[3:0];
  endfunction

  function automatic logic [PHYS_W-1:0] seg_addr(input logic [REG_W-1:0] m,
                                                 input logic [WIN_W-1:0] o);
    return (PHYS_W'(m[SEG_W-1:0]) << WIN_W) + PHYS_W'(o);
  endfunction

  function automatic logic [PHYS_W-1:0] data_addr(input logic [REG_W-1:0] m,
                                                  input logic [ADDR_W-1:0] a);
    return (PHYS_W'(m[SEG_W-1:0]) << DATA_SEG_SHIFT) + PHYS_W'(a);
  endfunction

  always_comb begin
    lk_paddr = '0;
    lk_space = SPC_NONE;
    lk_len   = '0;
    lk_err   = 1'b1;
    if (!out_rng) begin
      if (map_w[MAP_IO_BIT]) begin
        lk_paddr = (PHYS_W'(io_page(map_w, woff)) << IO_PAGE_SHIFT)
                 + PHYS_W'(IO_BASE) + PHYS_W'(woff);
        lk_space = SPC_DATA;
        lk_len   = clip_len(woff, lk_count);
        lk_err   = 1'b0;
      end else begin
        unique case (map_w[MAP_SP_HI:MAP_SP_LO])
          2'b00: begin
            lk_paddr = seg_addr(map_w, woff);
            lk_space = SPC_UNIFIED;
            lk_len   = clip_len(woff, lk_count);
            lk_err   = 1'b0;
          end
          2'b01: begin
            lk_paddr = seg_addr(map_w, woff);
            lk_space = SPC_INSN;
            lk_len   = clip_len(woff, lk_count);
            lk_err   = 1'b0;
          end
          2'b10: begin
            lk_paddr = data_addr(map_w, la);
            lk_space = SPC_DATA;
            lk_len   = clip_len(woff, lk_count);
            lk_err   = 1'b0;
          end
          default: begin
            lk_err = 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dwat_top.sv
module dwat_top #(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 16,
  parameter int REG_W   = 16,
  parameter int SEG_W   = 10,
  parameter int PHYS_W  = 26,
  parameter int CNT_W   = 16,
  parameter bit WRAP    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W:0]   lk_offset,
  input  logic [CNT_W-1:0]  lk_count,
  output logic [PHYS_W-1:0] lk_paddr,
  output logic [1:0]        lk_space,
  output logic [CNT_W-1:0]  lk_len,
  output logic              lk_err
);
  localparam int IDX_W     = $clog2(NUM_WIN);
  localparam int WIN_W     = ADDR_W - IDX_W;
  localparam int WIN_BYTES = 1 << WIN_W;

  logic [NUM_WIN-1:0][REG_W-1:0] maps;
  logic [IDX_W-1:0]              win_sel;
  logic                          sel_io;

  dwat_mapregs #(
    .NUM_WIN(NUM_WIN), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .maps(maps)
  );

  dwat_xlate #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_W(REG_W), .SEG_W(SEG_W),
    .PHYS_W(PHYS_W), .CNT_W(CNT_W), .WRAP(WRAP)
  ) u_xlate (
    .maps(maps), .lk_offset(lk_offset), .lk_count(lk_count),
    .lk_paddr(lk_paddr), .lk_space(lk_space), .lk_len(lk_len), .lk_err(lk_err)
  );

  assign win_sel = lk_offset[ADDR_W-1:WIN_W];
  assign sel_io  = maps[win_sel][dwat_pkg::MAP_IO_BIT];

  // R8 / R2: failed lookups carry nothing
  a_r8_err_empty: assert property (@(posedge clk) disable iff (rst)
    lk_err |-> (lk_len == '0 && lk_space == 2'd3 && lk_paddr == '0));

  // R4: never longer than requested
  a_r4_len_bounded: assert property (@(posedge clk) disable iff (rst)
    !lk_err |-> lk_len <= lk_count);

  // R4: transfer stays inside its window
  a_r4_within_window: assert property (@(posedge clk) disable iff (rst)
    !lk_err |-> (32'(lk_offset[WIN_W-1:0]) + 32'(lk_len)) <= WIN_BYTES);

  // R9: I/O windows land above the fixed base in data space
  a_r9_io_base: assert property (@(posedge clk) disable iff (rst)
    (!lk_err && sel_io) |-> (lk_paddr[15:14] == 2'b11 && lk_space == 2'd2));
endmodule

// File: tb/sim_dwat_top.sv
module sim_dwat_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_addr, wr_data;
  logic [16:0] lk_offset;
  logic [15:0] lk_count;
  logic [25:0] pa0, pa1;
  logic [1:0]  sp0, sp1;
  logic [15:0] ln0, ln1;
  logic        er0, er1;

  int checks = 0;
  int errors = 0;
  int mdl [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dwat_top u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lk_offset(lk_offset), .lk_count(lk_count),
    .lk_paddr(pa0), .lk_space(sp0), .lk_len(ln0), .lk_err(er0));

  dwat_top #(.WRAP(1'b1)) u1 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lk_offset(lk_offset), .lk_count(lk_count),
    .lk_paddr(pa1), .lk_space(sp1), .lk_len(ln1), .lk_err(er1));

  task automatic model_write(input int a, input int d);
    if (a == 'hFF04) mdl[2] = d;
    else if (a >= 'hFF08 && a <= 'hFF0E && (a % 2) == 0) mdl[(a - 'hFF08) / 2] = d;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[15:0]; wr_data = d[15:0];
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // expected result from the requirement text
  task automatic expect_of(input int off, input int cnt,
                           output int pa, output int sp, output int ln, output int er);
    int w, wo, m, sub, pg;
    pa = 0; sp = 3; ln = 0; er = 1;
    if (off < 65536) begin
      w = off / 16384; wo = off % 16384; m = mdl[w];
      if (wo + cnt > 16384) ln = 16384 - wo; else ln = cnt;
      er = 0;
      if ((m / 32768) % 2 == 1) begin
        sub = (wo / 4096) % 4;
        pg = (m >> (4 * (3 - sub))) % 16;
        pa = pg * 65536 + 49152 + wo; sp = 2;
      end else begin
        case ((m / 4096) % 4)
          0: begin pa = (m % 1024) * 16384 + wo; sp = 0; end
          1: begin pa = (m % 1024) * 16384 + wo; sp = 1; end
          2: begin pa = (m % 1024) * 65536 + w * 16384 + wo; sp = 2; end
          default: begin pa = 0; sp = 3; ln = 0; er = 1; end
        endcase
      end
    end
  endtask

  task automatic look(input string rq, input int off, input int cnt);
    int epa, esp, eln, eer;
    @(negedge clk);
    lk_offset = off[16:0]; lk_count = cnt[15:0];
    #1;
    expect_of(off, cnt, epa, esp, eln, eer);
    checks++;
    if (int'(pa0) != epa || int'(sp0) != esp || int'(ln0) != eln || int'(er0) != eer) begin
      errors++;
      $display("FAIL %s off=%h: got pa=%h sp=%0d len=%h err=%0d exp pa=%h sp=%0d len=%h err=%0d",
               rq, off, pa0, sp0, ln0, er0, epa, esp, eln, eer);
    end
  endtask

  task automatic t_reset;            // R11, R1, R5, R7
    look("R11", 'h0010, 4);
    look("R11", 'h4020, 4);
    look("R7",  'h8abc, 2);
    look("R5",  'hC123, 8);
  endtask

  task automatic t_clip;             // R4
    look("R4", 'h3FF0, 'h40);
    look("R4", 'h3FF0, 'h10);
    look("R4", 'h7FFF, 2);
    look("R4", 'h4000, 'hFFFF);
    look("R4", 'h0100, 0);
  endtask

  task automatic t_spaces;           // R5, R6, R7, R8
    wr('hFF08, 'h0123);
    wr('hFF0A, 'h1005);
    wr('hFF0C, 'h23FF);
    wr('hFF0E, 'h3000);
    look("R5", 'h0456, 16);
    look("R6", 'h7FFE, 16);
    look("R7", 'hA001, 3);
    look("R8", 'hC010, 5);
  endtask

  task automatic t_io;               // R9
    wr('hFF0A, 'hB5C7);
    for (int s = 0; s < 4; s++) look("R9", 'h4000 + s * 'h1000 + 'h123, 'h20);
    wr('hFF08, 'hF3A1);               // bits 13:12 = 11 but I/O wins
    look("R9", 'h3F00, 'h400);
  endtask

  task automatic t_decode;           // R10
    wr('hFF04, 'h1077);
    look("R10", 'h9000, 1);
    wr('hFF06, 'h3000);
    wr('hFF10, 'h3000);
    wr('h0F08, 'h3000);
    wr('hFF09, 'h3000);
    for (int w = 0; w < 4; w++) look("R10", w * 'h4000 + 'h20, 1);
  endtask

  task automatic t_range;            // R2, R3
    int epa, esp, eln, eer;
    look("R2", 'h10000, 4);
    look("R2", 'h1C123, 4);
    @(negedge clk);
    lk_offset = 17'h14321; lk_count = 16'h0040;
    #1;
    expect_of('h4321, 'h40, epa, esp, eln, eer);
    checks++;
    if (int'(pa1) != epa || int'(sp1) != esp || int'(ln1) != eln || int'(er1) != eer) begin
      errors++;
      $display("FAIL R3 wrap: got pa=%h sp=%0d len=%h err=%0d exp pa=%h sp=%0d len=%h err=%0d",
               pa1, sp1, ln1, er1, epa, esp, eln, eer);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    lk_offset = '0; lk_count = '0;
    mdl[0] = 'h2000; mdl[1] = 'h2000; mdl[2] = 'h2000; mdl[3] = 'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_clip;
    t_spaces;
    t_io;
    t_decode;
    t_range;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule